// File: doc/BRIEF.md
# Chirped Phase Generator with Phase Clear

This block produces the running phase for one sine-synthesis channel. The phase advances by a 32-bit frequency word every clock (one clock is one output sample), and that frequency word is itself advanced every sample by a 32-bit chirp word, so the output frequency ramps linearly. A 16-bit offset is added to the top of the accumulated phase on the way out. The 16-bit output feeds a downstream rotation stage. That stage has a gain of about 1.64676, which amplitude settings elsewhere must divide out.

Software writes the three coefficients as 16-bit words into a staging area. The words take effect only when the load trigger is pulsed, so a multi-word update appears atomically. An untriggered channel keeps running without any phase jump. A trigger likewise leaves the accumulated phase intact, so a frequency change stays phase-continuous. A separate phase-clear input zeroes the accumulated phase. It may coincide with a trigger to start a fresh waveform from phase zero.

A full turn of 360 degrees equals 2^16 output codes. At a 125 MHz sample rate the frequency word is 2^32·f/Fs and the chirp word is 2^32·rate/Fs².

Top module: `chirp_phase_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `phase_out` is 0, and the accumulator, frequency, chirp, offset and staging registers are all 0.
- R2: A write with `coef_wr` high stores `coef_word` into the staging slot chosen by `coef_slot`. The slots are: 0 = phase offset, 1 = frequency bits 15:0, 2 = frequency bits 31:16, 3 = chirp bits 15:0, 4 = chirp bits 31:16. Slot values 5 to 7 change nothing. A staged write never changes `phase_out` before a trigger.
- R3: On a clock edge with `load_trig` high, the live offset, frequency and chirp take the staged values as they were before that edge. A write in the same cycle lands in staging only. Without a trigger, the live offset and chirp hold.
- R4: On each clock edge without a trigger, the accumulator gains the current frequency word and the frequency word gains the current chirp word. Both updates use the pre-edge values and wrap modulo 2^32.
- R5: `phase_out` equals accumulator bits 31:16 plus the live offset, modulo 2^16.
- R6: A trigger does not reset the accumulator. On a trigger edge without phase clear, the accumulator still gains the frequency word that was live before the edge.
- R7: On an edge with `phase_clr` high, the accumulator becomes 0. Without a trigger, the frequency word still advances by the chirp word.
- R8: When `phase_clr` and `load_trig` are both high on the same edge, the accumulator becomes 0 and the new coefficients are loaded.
- R9: The accumulator and the frequency word wrap around silently. A frequency word of 0x8000_0000 advances `phase_out` by exactly 0x8000 per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one phase step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_wr | input | 1 | Stage `coef_word` into the slot selected by `coef_slot` |
| coef_slot | input | 3 | Staging slot index (0 to 4 used) |
| coef_word | input | 16 | Coefficient word to stage |
| load_trig | input | 1 | Move staged coefficients into the live registers |
| phase_clr | input | 1 | Zero the accumulated phase |
| phase_out | output | 16 | Offset phase for the rotation stage |

## Verification
The bench targets the edges where ordering matters.
- A write in the trigger cycle must not reach the live registers. A design that forwarded it would load a half-updated frequency.
- A trigger must not restart the phase. A design that zeroed the accumulator on load would show a phase jump on every retune.
- Phase clear together with a trigger must both zero and load. A design that honoured only one of them would either keep the old phase or keep the old frequency.
- Unused slots and untriggered writes must leave the output untouched.
- The pre-edge (parallel) update order is pinned by a chirp test, where a chained update would run one chirp step ahead.
- Wraparound is checked with a half-turn frequency.

// File: rtl/chirp_phase_pkg.sv
package chirp_phase_pkg;

    localparam int WORD_W    = 16;
    localparam int PH_W      = 16;
    localparam int ACC_W     = 32;
    localparam int FTW_W     = 32;
    localparam int SEL_W     = 3;
    localparam int FTW_WORDS = FTW_W / WORD_W;
    localparam int OFFS_SLOT  = 0;
    localparam int FTW_BASE   = OFFS_SLOT + 1;
    localparam int CHIRP_BASE = FTW_BASE + FTW_WORDS;

    typedef struct packed {
        logic [PH_W-1:0]  offs;
        logic [FTW_W-1:0] ftw;
        logic [FTW_W-1:0] chirp;
    } coef_set_t;

    typedef enum logic [1:0] {
        ACT_RUN        = 2'd0,
        ACT_LOAD       = 2'd1,
        ACT_CLEAR      = 2'd2,
        ACT_CLEAR_LOAD = 2'd3
    } act_e;

    function automatic act_e decode_act(input logic trig, input logic clr);
        act_e a;
        unique case ({clr, trig})
            2'b01:   a = ACT_LOAD;
            2'b10:   a = ACT_CLEAR;
            2'b11:   a = ACT_CLEAR_LOAD;
            default: a = ACT_RUN;
        endcase
        return a;
    endfunction

    function automatic logic act_loads(input act_e a);
        return (a == ACT_LOAD) || (a == ACT_CLEAR_LOAD);
    endfunction

    function automatic logic act_clears(input act_e a);
        return (a == ACT_CLEAR) || (a == ACT_CLEAR_LOAD);
    endfunction

    function automatic logic slot_hit(input logic [SEL_W-1:0] sel, input int slot);
        return sel == SEL_W'(slot);
    endfunction

endpackage

// File: rtl/chirp_coef_stage.sv
module chirp_coef_stage
    import chirp_phase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [SEL_W-1:0]  slot,
    input  logic [WORD_W-1:0] word,
    output coef_set_t         staged
);

    logic [PH_W-1:0]   offs_q;
    logic [WORD_W-1:0] ftw_q   [FTW_WORDS];
    logic [WORD_W-1:0] chirp_q [FTW_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            offs_q <= '0;
        end else if (wr && slot_hit(slot, OFFS_SLOT)) begin
            offs_q <= word[PH_W-1:0];
        end
    end

    for (genvar i = 0; i < FTW_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                ftw_q[i]   <= '0;
                chirp_q[i] <= '0;
            end else if (wr) begin
                if (slot_hit(slot, FTW_BASE + i)) begin
                    ftw_q[i] <= word;
                end
                if (slot_hit(slot, CHIRP_BASE + i)) begin
                    chirp_q[i] <= word;
                end
            end
        end
        assign staged.ftw[i*WORD_W +: WORD_W]   = ftw_q[i];
        assign staged.chirp[i*WORD_W +: WORD_W] = chirp_q[i];
    end

    assign staged.offs = offs_q;

endmodule

// File: rtl/chirp_freq_ramp.sv
module chirp_freq_ramp
    import chirp_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [FTW_W-1:0] load_ftw,
    input  logic [FTW_W-1:0] load_chirp,
    output logic [FTW_W-1:0] ftw,
    output logic [FTW_W-1:0] chirp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw   <= '0;
            chirp <= '0;
        end else if (load) begin
            ftw   <= load_ftw;
            chirp <= load_chirp;
        end else begin
            ftw   <= ftw + chirp;
        end
    end

endmodule

// File: rtl/chirp_phase_accum.sv
module chirp_phase_accum
    import chirp_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [FTW_W-1:0] ftw,
    output logic [ACC_W-1:0] acc
);

    localparam int PAD_W = ACC_W - FTW_W;

    logic [ACC_W-1:0] step;

    if (PAD_W > 0) begin : g_pad
        assign step = {{PAD_W{1'b0}}, ftw};
    end else begin : g_nopad
        assign step = ftw[FTW_W-1 -: ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else begin
            acc <= acc + step;
        end
    end

endmodule

// File: rtl/chirp_phase_gen.sv
module chirp_phase_gen
    import chirp_phase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_wr,
    input  logic [SEL_W-1:0]  coef_slot,
    input  logic [WORD_W-1:0] coef_word,
    input  logic              load_trig,
    input  logic              phase_clr,
    output logic [PH_W-1:0]   phase_out
);

    coef_set_t        staged;
    act_e             act;
    logic [PH_W-1:0]  offs_q;
    logic [FTW_W-1:0] ftw;
    logic [FTW_W-1:0] chirp;
    logic [ACC_W-1:0] acc;

    assign act = decode_act(load_trig, phase_clr);

    chirp_coef_stage i_stage (
        .clk    (clk),
        .rst    (rst),
        .wr     (coef_wr),
        .slot   (coef_slot),
        .word   (coef_word),
        .staged (staged)
    );

    chirp_freq_ramp i_ramp (
        .clk        (clk),
        .rst        (rst),
        .load       (act_loads(act)),
        .load_ftw   (staged.ftw),
        .load_chirp (staged.chirp),
        .ftw        (ftw),
        .chirp      (chirp)
    );

    chirp_phase_accum i_accum (
        .clk   (clk),
        .rst   (rst),
        .clear (act_clears(act)),
        .ftw   (ftw),
        .acc   (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            offs_q <= '0;
        end else if (act_loads(act)) begin
            offs_q <= staged.offs;
        end
    end

    assign phase_out = acc[ACC_W-1 -: PH_W] + offs_q;

endmodule

// File: rtl/chirp_phase_chk.sv
module chirp_phase_chk
    import chirp_phase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             coef_wr,
    input  logic             load_trig,
    input  logic             phase_clr,
    input  logic [PH_W-1:0]  phase_out,
    input  coef_set_t        staged,
    input  logic [PH_W-1:0]  offs_q,
    input  logic [FTW_W-1:0] ftw,
    input  logic [FTW_W-1:0] chirp,
    input  logic [ACC_W-1:0] acc
);

    // R2: staging only changes on a write
    a_r2_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !coef_wr |=> $stable(staged));

    // R3: a trigger moves the pre-edge staged frequency and chirp to the live registers
    a_r3_load_ftw: assert property (@(posedge clk) disable iff (rst)
        load_trig |=> (ftw == $past(staged.ftw)) && (chirp == $past(staged.chirp)));

    // R3: without a trigger the live offset and chirp hold
    a_r3_hold_live: assert property (@(posedge clk) disable iff (rst)
        !load_trig |=> $stable(chirp) && $stable(offs_q));

    // R7: phase clear zeroes the accumulator
    a_r7_clear_acc: assert property (@(posedge clk) disable iff (rst)
        phase_clr |=> acc == '0);

    // R5: after a clear the output is the live offset alone
    a_r5_clear_out: assert property (@(posedge clk) disable iff (rst)
        phase_clr |=> phase_out == offs_q);

endmodule

bind chirp_phase_gen chirp_phase_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .coef_wr   (coef_wr),
    .load_trig (load_trig),
    .phase_clr (phase_clr),
    .phase_out (phase_out),
    .staged    (staged),
    .offs_q    (offs_q),
    .ftw       (ftw),
    .chirp     (chirp),
    .acc       (acc)
);

// File: tb/test_chirp_phase_gen.sv
`timescale 1ns/1ps
module test_chirp_phase_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        coef_wr = 1'b0;
    logic [2:0]  coef_slot = '0;
    logic [15:0] coef_word = '0;
    logic        load_trig = 1'b0;
    logic        phase_clr = 1'b0;
    logic [15:0] phase_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [15:0] m_offs, s_offs;
    logic [31:0] m_ftw, m_chirp, m_acc, s_ftw, s_chirp;

    chirp_phase_gen i_chirp_phase_gen (
        .clk(clk), .rst(rst), .coef_wr(coef_wr), .coef_slot(coef_slot),
        .coef_word(coef_word), .load_trig(load_trig), .phase_clr(phase_clr),
        .phase_out(phase_out)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_phase();
        return m_acc[31:16] + m_offs;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s phase_out actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_offs = '0; s_offs = '0;
        m_ftw = '0; m_chirp = '0; m_acc = '0; s_ftw = '0; s_chirp = '0;
    endtask

    // R4 R6 R7 R8: model update from pre-edge values; R3: trigger sees old staging
    task automatic model_edge(input bit we, input logic [2:0] sl, input logic [15:0] d,
                              input bit tg, input bit pc);
        logic [31:0] n_acc;
        n_acc = pc ? 32'd0 : m_acc + m_ftw;
        if (tg) begin
            m_ftw = s_ftw; m_chirp = s_chirp; m_offs = s_offs;
        end else begin
            m_ftw = m_ftw + m_chirp;
        end
        m_acc = n_acc;
        if (we) begin
            case (sl)
                3'd0: s_offs = d;
                3'd1: s_ftw[15:0] = d;
                3'd2: s_ftw[31:16] = d;
                3'd3: s_chirp[15:0] = d;
                3'd4: s_chirp[31:16] = d;
                default: ;
            endcase
        end
    endtask

    task automatic step(input bit we, input logic [2:0] sl, input logic [15:0] d,
                        input bit tg, input bit pc);
        coef_wr = we; coef_slot = sl; coef_word = d; load_trig = tg; phase_clr = pc;
        @(posedge clk);
        model_edge(we, sl, d, tg, pc);
        @(negedge clk);
        chk(cur_req, phase_out, exp_phase());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic stage_all(input logic [15:0] o, input logic [31:0] f, input logic [31:0] c);
        step(1'b1, 3'd0, o, 1'b0, 1'b0);
        step(1'b1, 3'd1, f[15:0], 1'b0, 1'b0);
        step(1'b1, 3'd2, f[31:16], 1'b0, 1'b0);
        step(1'b1, 3'd3, c[15:0], 1'b0, 1'b0);
        step(1'b1, 3'd4, c[31:16], 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] base;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", phase_out, 16'h0000);
        rst = 1'b0;
        idle(2);
        chk("R1", phase_out, 16'h0000);

        // R2: staged words do not reach the output; unused slots ignored
        cur_req = "R2";
        stage_all(16'h0100, 32'h0001_0000, 32'h0);
        step(1'b1, 3'd5, 16'hFFFF, 1'b0, 1'b0);
        step(1'b1, 3'd7, 16'hFFFF, 1'b0, 1'b0);
        idle(3);
        chk("R2", phase_out, 16'h0000);

        // R3 R5 R6: trigger loads; trigger edge adds old ftw (0)
        cur_req = "R3";
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
        chk("R3", phase_out, 16'h0100);
        cur_req = "R5";
        idle(10);
        chk("R5", phase_out, 16'h010A);

        // R6: retune without phase reset; trigger edge still adds old ftw
        cur_req = "R6";
        step(1'b1, 3'd2, 16'h0002, 1'b0, 1'b0);
        base = phase_out;
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
        chk("R6", phase_out, base + 16'h0001);
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        chk("R6", phase_out, base + 16'h0003);

        // R3: write in the trigger cycle lands in staging only
        cur_req = "R3";
        step(1'b1, 3'd2, 16'h0005, 1'b1, 1'b0);
        base = phase_out;
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        chk("R3", phase_out, base + 16'h0002);

        // R4: chirp, parallel update order
        cur_req = "R4";
        stage_all(16'h0000, 32'h0, 32'h0001_0000);
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        chk("R8", phase_out, 16'h0000);
        idle(4);
        // ftw: 0,1,2,3 (x 2^16) added before each edge -> acc hi = 0+1+2+3 = 6
        chk("R4", phase_out, 16'h0006);

        // R7: clear alone keeps the ramp going
        cur_req = "R7";
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1);
        chk("R7", phase_out, 16'h0000);
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        chk("R7", phase_out, 16'h0005);

        // R8: clear with trigger zeroes and loads
        cur_req = "R8";
        stage_all(16'h1234, 32'h0002_0000, 32'h0);
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        chk("R8", phase_out, 16'h1234);
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        chk("R8", phase_out, 16'h1236);

        // R9: half-turn frequency wraps
        cur_req = "R9";
        stage_all(16'h0000, 32'h8000_0000, 32'h0);
        step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        chk("R9", phase_out, 16'h8000);
        step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
        chk("R9", phase_out, 16'h0000);

        // R4 R9: random mix against the model
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, 3'($urandom % 8), 16'($urandom),
                 ($urandom % 16) == 0, ($urandom % 40) == 0);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule